// File: doc/BRIEF.md
# Iterative Feistel Round Engine

This block encrypts one 64-bit data block under a 128-bit key with a 32-round Feistel network of the extended tiny cipher family. The block is handled as two 32-bit unsigned halves. Each round mixes both halves through shifts, XOR and modulo-2^32 additions, and it advances a running sum by a fixed constant. The engine completes one full round in every clock cycle, so a block takes 32 cycles from acceptance to result.

A request is a single-cycle (or held) `start` together with the block and the key. `start` acts as the input valid. `!busy` is the matching ready: a request is taken only on a cycle where `busy` is low, and it is dropped when `busy` is high, so the requester holds `start` until it sees `busy`. `done` is the output valid for one cycle. No back-pressure on the result is needed because `blk_out` stays frozen until the next accepted request. Decryption, key storage and chaining modes are outside this block.

Top module: `feistel_round_engine`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `busy` and `done` are 0 and `blk_out` is all zeros.
- R2: When `start` is high and `busy` is low at a rising edge, the engine captures `blk_in` (half v0 = bits [31:0], v1 = bits [63:32]) and `key_in`, clears the sum and round index to 0, and shows `busy` high after that edge.
- R3: Each round replaces v0 with v0 + ((k + sum) XOR (v1 + ((v1 << 4) XOR (v1 >> 5)))), all modulo 2^32.
- R4: Each round then adds 0x9E3779B9 to the sum and replaces v1 with v1 + ((k + new sum) XOR (new v0 + ((new v0 << 4) XOR (new v0 >> 5)))).
- R5: The subkey k of round r (r = 0..31) is key word r mod 4, where word i is `key_in` bits [32*i+31 : 32*i].
- R6: `busy` stays high for exactly 32 cycles per request. On the edge that ends the 32nd round, `busy` falls, and `done` is high for that one cycle only.
- R7: While `busy` is low and no request is accepted, `blk_out` keeps its value, whatever `blk_in` and `key_in` do.
- R8: A `start` seen while `busy` is high has no effect: the current result, its timing and its value stay unchanged.
- R9: Both shifts are logical, with zero fill, so data with the top bits set gives the same result as the equations in R3 and R4.
- R10: A request raised in the cycle where `done` is high is accepted at once, and it produces its own correct result 32 cycles later.
- R11: `blk_out` presents the final halves with v0 in bits [31:0] and v1 in bits [63:32].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request valid; accepted only while `busy` is low |
| blk_in | input | 64 | Plaintext block, v0 in [31:0], v1 in [63:32] |
| key_in | input | 128 | Cipher key, word i in [32*i+31:32*i] |
| busy | output | 1 | Round computation in progress; inverse of request ready |
| done | output | 1 | One-cycle pulse marking the result as new |
| blk_out | output | 64 | Encrypted block, held until the next accepted request |

## Verification
The hardest situation to create from the ports is a request that falls inside a run: it has to arrive at a chosen round, and it must leave both the result and the 32-cycle timing alone. The bench raises `start` with a different block and key in the middle of a run. It then checks the round count and the final value against the first request only. It also re-arms `start` in the exact cycle where `done` is high, to cover a request that lands on the boundary between runs.

// File: rtl/xr_pkg.sv
package xr_pkg;

  typedef enum logic {
    XR_IDLE = 1'b0,
    XR_RUN  = 1'b1
  } xr_state_e;

  localparam int unsigned XR_DEF_WORD  = 32;
  localparam int unsigned XR_DEF_NKEY  = 4;
  localparam int unsigned XR_DEF_ROUND = 32;
  localparam logic [31:0] XR_DEF_DELTA = 32'h9E37_79B9;

endpackage

// File: rtl/xr_subkey.sv
module xr_subkey #(
  parameter int unsigned W    = 32,
  parameter int unsigned NKEY = 4,
  parameter int unsigned CW   = 5
) (
  input  logic [NKEY*W-1:0] key,
  input  logic [CW-1:0]     round_idx,
  output logic [W-1:0]      subkey
);

  localparam int unsigned IDXW = (NKEY > 1) ? $clog2(NKEY) : 1;

  logic [W-1:0]    words [NKEY];
  logic [IDXW-1:0] sel;

  for (genvar g = 0; g < NKEY; g++) begin : g_split
    assign words[g] = key[g*W +: W];
  end

  assign sel    = IDXW'(round_idx % NKEY);
  assign subkey = words[sel];

endmodule

// File: rtl/xr_round.sv
module xr_round #(
  parameter int unsigned W     = 32,
  parameter int unsigned SHL   = 4,
  parameter int unsigned SHR   = 5,
  parameter logic [W-1:0] DELTA = 32'h9E37_79B9
) (
  input  logic [W-1:0] v0,
  input  logic [W-1:0] v1,
  input  logic [W-1:0] sum,
  input  logic [W-1:0] k,
  output logic [W-1:0] v0_nx,
  output logic [W-1:0] v1_nx,
  output logic [W-1:0] sum_nx
);

  function automatic logic [W-1:0] spread(input logic [W-1:0] x);
    return ((x << SHL) ^ (x >> SHR)) + x;
  endfunction

  logic [W-1:0] left_term;
  logic [W-1:0] right_term;

  always_comb begin
    left_term  = (k + sum) ^ spread(v1);
    v0_nx      = v0 + left_term;
    sum_nx     = sum + DELTA;
    right_term = (k + sum_nx) ^ spread(v0_nx);
    v1_nx      = v1 + right_term;
  end

endmodule

// File: rtl/xr_ctrl.sv
module xr_ctrl
  import xr_pkg::*;
#(
  parameter int unsigned ROUNDS = 32,
  parameter int unsigned CW     = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          load,
  output logic          step,
  output logic [CW-1:0] round_idx,
  output logic          busy,
  output logic          done
);

  localparam logic [CW-1:0] LAST = CW'(ROUNDS - 1);

  xr_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;
  logic          last;

  assign busy      = (state_q == XR_RUN);
  assign load      = start && !busy;
  assign step      = busy;
  assign last      = step && (cnt_q == LAST);
  assign round_idx = cnt_q;
  assign done      = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= XR_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= last;
      if (load) begin
        state_q <= XR_RUN;
        cnt_q   <= '0;
      end else if (step) begin
        cnt_q <= cnt_q + 1'b1;
        if (last) state_q <= XR_IDLE;
      end
    end
  end

endmodule

// File: rtl/feistel_round_engine.sv
module feistel_round_engine
  import xr_pkg::*;
#(
  parameter int unsigned  W      = XR_DEF_WORD,
  parameter int unsigned  NKEY   = XR_DEF_NKEY,
  parameter int unsigned  ROUNDS = XR_DEF_ROUND,
  parameter int unsigned  SHL    = 4,
  parameter int unsigned  SHR    = 5,
  parameter logic [W-1:0] DELTA  = XR_DEF_DELTA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [2*W-1:0]    blk_in,
  input  logic [NKEY*W-1:0] key_in,
  output logic              busy,
  output logic              done,
  output logic [2*W-1:0]    blk_out
);

  localparam int unsigned CW = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;

  logic              load;
  logic              step;
  logic [CW-1:0]     round_idx;
  logic [W-1:0]      v0_q, v1_q, sum_q;
  logic [NKEY*W-1:0] key_q;
  logic [W-1:0]      k_cur;
  logic [W-1:0]      v0_nx, v1_nx, sum_nx;

  xr_ctrl #(.ROUNDS(ROUNDS), .CW(CW)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .load      (load),
    .step      (step),
    .round_idx (round_idx),
    .busy      (busy),
    .done      (done)
  );

  xr_subkey #(.W(W), .NKEY(NKEY), .CW(CW)) u_subkey (
    .key       (key_q),
    .round_idx (round_idx),
    .subkey    (k_cur)
  );

  xr_round #(.W(W), .SHL(SHL), .SHR(SHR), .DELTA(DELTA)) u_round (
    .v0     (v0_q),
    .v1     (v1_q),
    .sum    (sum_q),
    .k      (k_cur),
    .v0_nx  (v0_nx),
    .v1_nx  (v1_nx),
    .sum_nx (sum_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      v0_q  <= '0;
      v1_q  <= '0;
      sum_q <= '0;
      key_q <= '0;
    end else if (load) begin
      v0_q  <= blk_in[W-1:0];
      v1_q  <= blk_in[2*W-1:W];
      sum_q <= '0;
      key_q <= key_in;
    end else if (step) begin
      v0_q  <= v0_nx;
      v1_q  <= v1_nx;
      sum_q <= sum_nx;
    end
  end

  assign blk_out = {v1_q, v0_q};

endmodule

// File: rtl/feistel_round_engine_chk.sv
module feistel_round_engine_chk #(
  parameter int unsigned W      = 32,
  parameter int unsigned ROUNDS = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [2*W-1:0] blk_out
);

  int unsigned run_len;

  always_ff @(posedge clk) begin
    if (rst || !busy) run_len <= 0;
    else              run_len <= run_len + 1;
  end

  // R1: outputs idle right after reset
  p_reset_idle_r1: assert property (@(posedge clk) rst |=> (!busy && !done && blk_out == '0));

  // R2: an idle request raises busy
  p_accept_r2: assert property (@(posedge clk) disable iff (rst) (start && !busy) |=> busy);

  // R6: done is a single-cycle pulse tied to the fall of busy
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  p_done_on_fall_r6: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> done);
  p_fall_on_done_r6: assert property (@(posedge clk) disable iff (rst) done |-> !busy);

  // R6, R8: busy lasts exactly ROUNDS cycles regardless of start
  p_run_short_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && run_len < ROUNDS - 1) |=> busy);
  p_run_end_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && run_len == ROUNDS - 1) |=> !busy);

  // R7: idle result holds
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start && !done) |=> $stable(blk_out));

endmodule

bind feistel_round_engine feistel_round_engine_chk #(.W(W), .ROUNDS(ROUNDS)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .blk_out (blk_out)
);

// File: tb/test_feistel_round_engine.sv
`timescale 1ns/1ps
module test_feistel_round_engine;

  localparam int NR = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [63:0]  blk_in = '0;
  logic [127:0] key_in = '0;
  logic         busy, done;
  logic [63:0]  blk_out;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  feistel_round_engine i_feistel_round_engine (
    .clk(clk), .rst(rst), .start(start), .blk_in(blk_in), .key_in(key_in),
    .busy(busy), .done(done), .blk_out(blk_out)
  );

  // stimulus table: {key, block}
  localparam logic [191:0] VEC [6] = '{
    {128'h0, 64'h0},
    {128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF, 64'hFFFFFFFF_FFFFFFFF},
    {128'h00010203_04050607_08090A0B_0C0D0E0F, 64'h41424344_45464748},
    {128'hDEADBEEF_00000000_00000000_00000000, 64'h80000000_80000001},
    {128'h00000000_00000000_00000000_CAFEF00D, 64'h80000000_80000001},
    {128'h12345678_9ABCDEF0_0F1E2D3C_4B5A6978, 64'hF0F0F0F0_0F0F0F0F}
  };

  function automatic logic [31:0] mixf(input logic [31:0] x);
    return ((x << 4) ^ (x >> 5)) + x;
  endfunction

  function automatic logic [63:0] ref_enc(input logic [63:0] d, input logic [127:0] k);
    logic [31:0] a, b, s, kw;
    a = d[31:0];
    b = d[63:32];
    s = 32'h0;
    for (int r = 0; r < NR; r++) begin
      kw = k[32*(r%4) +: 32];
      a  = a + ((kw + s) ^ mixf(b));
      s  = s + 32'h9E3779B9;
      b  = b + ((kw + s) ^ mixf(a));
    end
    return {b, a};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic launch(input logic [63:0] d, input logic [127:0] k);
    start  = 1'b1;
    blk_in = d;
    key_in = k;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R2 busy after accept", 128'(busy), 128'd1);
  endtask

  // optional mid-run request at cycle inj (0 = none)
  task automatic finish(input logic [63:0] exp, input int inj, input string tag);
    int cyc = 0;
    while (busy === 1'b1 && cyc < 100) begin
      cyc++;
      if (inj != 0 && cyc == inj) begin
        start  = 1'b1;
        blk_in = ~blk_in;
        key_in = {key_in[63:0], key_in[127:64]} ^ 128'h5A5A;
      end
      @(negedge clk);
      start = 1'b0;
    end
    check(cyc == NR, {tag, " R6 busy length"}, 128'(cyc), 128'(NR));
    check(done === 1'b1, {tag, " R6 done with busy fall"}, 128'(done), 128'd1);
    check(blk_out === exp, {tag, " R3 R4 R5 R9 R11 result"}, 128'(blk_out), 128'(exp));
  endtask

  initial begin
    #(5.0 * 20000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [63:0]  d, e, held;
    logic [127:0] k;
    repeat (3) @(negedge clk);
    // R1
    check(busy === 1'b0 && done === 1'b0 && blk_out === 64'h0, "R1 reset state",
          {busy, done, blk_out}, 128'h0);
    rst = 1'b0;
    @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && blk_out === 64'h0, "R1 after reset",
          {busy, done, blk_out}, 128'h0);

    // table walk
    for (int i = 0; i < 6; i++) begin
      d = VEC[i][63:0];
      k = VEC[i][191:64];
      launch(d, k);
      finish(ref_enc(d, k), 0, $sformatf("vec%0d", i));
      @(negedge clk);
      check(done === 1'b0, "R6 done one cycle", 128'(done), 128'd0);
    end

    // random vectors
    for (int i = 0; i < 4; i++) begin
      d = {$urandom, $urandom};
      k = {$urandom, $urandom, $urandom, $urandom};
      launch(d, k);
      finish(ref_enc(d, k), 0, $sformatf("rnd%0d", i));
      @(negedge clk);
    end

    // R7: result held while idle with moving inputs
    held = blk_out;
    for (int i = 0; i < 8; i++) begin
      blk_in = {$urandom, $urandom};
      key_in = {$urandom, $urandom, $urandom, $urandom};
      @(negedge clk);
    end
    check(blk_out === held, "R7 idle hold", 128'(blk_out), 128'(held));

    // R8: start mid-run ignored
    d = 64'h01234567_89ABCDEF;
    k = 128'hA5A5A5A5_5A5A5A5A_3C3C3C3C_C3C3C3C3;
    launch(d, k);
    finish(ref_enc(d, k), 7, "R8 mid-run start");
    e = ref_enc(d, k);

    // R10: request in the done cycle
    d = 64'h13579BDF_2468ACE0;
    k = 128'h11111111_22222222_33333333_44444444;
    launch(d, k);
    finish(ref_enc(d, k), 0, "R10 restart");
    check(ref_enc(d, k) !== e, "R10 distinct result", 128'(ref_enc(d, k)), 128'(e));
    @(negedge clk);
    check(done === 1'b0 && busy === 1'b0, "R10 idle after", {done, busy}, 128'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule